// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a synchronous RAM with two fully independent access ports, a left one and a right one. Each port has a chip enable, an address, a write strobe, per-lane byte enables and its own write and read data. The two ports can read or write different locations in the same cycle and never wait for each other. The one case that needs care is both ports selecting the same word in the same cycle. A small arbiter detects this case and settles it.

A strap input chooses between two roles. In the master role, the arbiter picks a winning port for each collision and pulls the active-low busy output of the losing port low. A write from the losing port is discarded inside the block. In the slave role, the arbiter's outputs are not used. Each port then has an active-low inhibit input that blocks that port's writes. This lets a master instance steer several slave instances that share its address range, so that a wide word is either written in full or not at all. Reads are never blocked. Read data appears one cycle after the request and shows the contents as they were before any write in that same cycle.

Top module: `dpr_collide_top`

## Requirements
- R1: In master role (`master_mode`=1), a collision is both `*_ce` high with equal addresses in the same cycle. In that cycle, exactly one of `l_busy_n_o`/`r_busy_n_o` is low, combinationally from the current inputs. In any cycle without a collision, both are high.
- R2: The arbitration outcome depends only on chip enables and addresses. The values of `*_we`, `*_be` and `*_wdata` never change which port is busy.
- R3: A write from the port that loses a collision in master role leaves every lane of the addressed word unchanged. The winning port's write is stored.
- R4: If a collision was also present in the previous cycle, the port that won in the previous cycle wins again.
- R5: On a collision that was not present in the previous cycle, a port counts as settled if it was enabled at the same address in the previous cycle. If exactly one port is settled, that port wins. Otherwise the left port wins.
- R6: In slave role (`master_mode`=0), both busy outputs stay high and collisions block nothing. A low `*_busy_n_i` blocks every write of that port. A high `*_busy_n_i` lets writes proceed. If both ports write the same lane of the same address, the right port's data is kept. In master role, `*_busy_n_i` has no effect.
- R7: Byte-enable bit k controls data bits [k*LANE_W +: LANE_W]. Only lanes whose enable is 1 are written, and the other lanes keep their contents.
- R8: A read (`ce`=1, `we`=0) returns, one cycle later, the word as it was before any write in the same cycle. This includes a read that loses a collision. `*_rdata` holds its value in every cycle without a read.
- R9: Accesses to different addresses proceed on both ports in the same cycle without affecting each other.
- R10: After reset, both busy outputs are high and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs inhibit writes |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left word address |
| l_be | input | LANES | Left byte-lane enables |
| l_wdata | input | LANES*LANE_W | Left write data |
| l_rdata | output | LANES*LANE_W | Left read data, one cycle latency |
| l_busy_n_i | input | 1 | Left write inhibit, active low, slave role only |
| l_busy_n_o | output | 1 | Left busy flag, active low, master role |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right word address |
| r_be | input | LANES | Right byte-lane enables |
| r_wdata | input | LANES*LANE_W | Right write data |
| r_rdata | output | LANES*LANE_W | Right read data, one cycle latency |
| r_busy_n_i | input | 1 | Right write inhibit, active low, slave role only |
| r_busy_n_o | output | 1 | Right busy flag, active low, master role |

## Verification
The bench builds the block with 16 words of two 8-bit lanes. It draws most random addresses from a window of four words, so collisions, sustained collisions and staggered arrivals occur often. The two lanes allow partial-lane writes to be checked against untouched neighbours. Because the depth is small, the whole array can be preloaded, and every later read can be compared with a reference copy.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              coll_o,
  output win_e              win_o,
  output logic              l_lose_o,
  output logic              r_lose_o
);
  logic              pl_ce_q, pr_ce_q, p_coll_q;
  logic [ADDR_W-1:0] pl_addr_q, pr_addr_q;
  win_e              p_win_q;
  logic              l_settled, r_settled;

  always_comb begin
    coll_o    = l_ce & r_ce & (l_addr == r_addr);
    l_settled = pl_ce_q & l_ce & (pl_addr_q == l_addr);
    r_settled = pr_ce_q & r_ce & (pr_addr_q == r_addr);
    if (p_coll_q)                    win_o = p_win_q;
    else if (r_settled & !l_settled) win_o = WIN_RIGHT;
    else                             win_o = WIN_LEFT;
    l_lose_o = coll_o & (win_o == WIN_RIGHT);
    r_lose_o = coll_o & (win_o == WIN_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_ce_q   <= 1'b0;
      pr_ce_q   <= 1'b0;
      pl_addr_q <= '0;
      pr_addr_q <= '0;
      p_coll_q  <= 1'b0;
      p_win_q   <= WIN_LEFT;
    end else begin
      pl_ce_q   <= l_ce;
      pr_ce_q   <= r_ce;
      pl_addr_q <= l_addr;
      pr_addr_q <= r_addr;
      p_coll_q  <= coll_o;
      p_win_q   <= win_o;
    end
  end

  p_single_loser_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l_lose_o, r_lose_o}));

  p_keep_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_o && $past(coll_o)) |-> (win_o == $past(win_o)));
endmodule

// File: rtl/dpr_wgate.sv
module dpr_wgate #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             ce,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic             lose,
  input  logic             inhibit_n,
  output logic             inh_o,
  output logic             rd_en_o,
  output logic [LANES-1:0] wr_be_o
);
  always_comb begin
    inh_o   = master ? lose : !inhibit_n;
    rd_en_o = ce & !we;
    wr_be_o = (ce & we & !inh_o) ? be : '0;
  end

  p_inhibit_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inh_o |-> (wr_be_o == '0));
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_rd_en,
  input  logic [LANES-1:0]  l_wr_be,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_rd_en,
  input  logic [LANES-1:0]  r_wr_be,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] l_q, r_q, l_d, r_d;

    always_ff @(posedge clk) begin
      if (l_wr_be[g]) store[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
      if (r_wr_be[g]) store[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
    end

    always_comb begin
      l_d = l_rd_en ? store[l_addr] : l_q;
      r_d = r_rd_en ? store[r_addr] : r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= '0;
        r_q <= '0;
      end else begin
        l_q <= l_d;
        r_q <= r_d;
      end
    end

    assign l_rdata_o[g*LANE_W +: LANE_W] = l_q;
    assign r_rdata_o[g*LANE_W +: LANE_W] = r_q;
  end

  p_rd_hold_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd_en |=> $stable(l_rdata_o));

  p_rd_hold_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd_en |=> $stable(r_rdata_o));
endmodule

// File: rtl/dpr_collide_top.sv
module dpr_collide_top
  import dpr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [LANES-1:0]  l_be,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_n_i,
  output logic              l_busy_n_o,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [LANES-1:0]  r_be,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_n_i,
  output logic              r_busy_n_o
);
  logic [1:0]       rst_pipe_q;
  logic             srst_n;
  logic             coll;
  win_e             win;
  logic             l_lose, r_lose, l_inh, r_inh, l_rd_en, r_rd_en;
  logic [LANES-1:0] l_wr_be, r_wr_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(srst_n),
    .l_ce(l_ce), .l_addr(l_addr), .r_ce(r_ce), .r_addr(r_addr),
    .coll_o(coll), .win_o(win), .l_lose_o(l_lose), .r_lose_o(r_lose)
  );

  dpr_wgate #(.LANES(LANES)) u_lgate (
    .clk(clk), .rst_n(srst_n), .master(master_mode),
    .ce(l_ce), .we(l_we), .be(l_be), .lose(l_lose), .inhibit_n(l_busy_n_i),
    .inh_o(l_inh), .rd_en_o(l_rd_en), .wr_be_o(l_wr_be)
  );

  dpr_wgate #(.LANES(LANES)) u_rgate (
    .clk(clk), .rst_n(srst_n), .master(master_mode),
    .ce(r_ce), .we(r_we), .be(r_be), .lose(r_lose), .inhibit_n(r_busy_n_i),
    .inh_o(r_inh), .rd_en_o(r_rd_en), .wr_be_o(r_wr_be)
  );

  dpr_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(srst_n),
    .l_rd_en(l_rd_en), .l_wr_be(l_wr_be), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata_o(l_rdata),
    .r_rd_en(r_rd_en), .r_wr_be(r_wr_be), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata_o(r_rdata)
  );

  always_comb begin
    l_busy_n_o = master_mode ? !l_lose : 1'b1;
    r_busy_n_o = master_mode ? !r_lose : 1'b1;
  end

  p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (master_mode && !(l_ce && r_ce && (l_addr == r_addr))) |->
      (l_busy_n_o && r_busy_n_o));

  p_coll_one_busy_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (master_mode && l_ce && r_ce && (l_addr == r_addr)) |->
      (l_busy_n_o != r_busy_n_o));

  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !master_mode |-> (l_busy_n_o && r_busy_n_o));

  p_loser_no_write_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (master_mode && !l_busy_n_o) |-> (l_wr_be == '0));
endmodule

// File: tb/sim_dpr_collide_top.sv
module sim_dpr_collide_top;
  localparam int DEPTH  = 16;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, master_mode;
  logic l_ce, l_we, r_ce, r_we, l_busy_n_i, r_busy_n_i;
  logic [AW-1:0] l_addr, r_addr;
  logic [LANES-1:0] l_be, r_be;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy_n_o, r_busy_n_o;

  dpr_collide_top #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n_i(l_busy_n_i), .l_busy_n_o(l_busy_n_o),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_be(r_be), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n_i(r_busy_n_i), .r_busy_n_o(r_busy_n_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] exp_l_rd, exp_r_rd;
  logic          pl_ce, pr_ce, p_coll, p_winr;
  logic [AW-1:0] pl_addr, pr_addr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [LANES-1:0] be);
    logic [DW-1:0] res = old;
    for (int k = 0; k < LANES; k++)
      if (be[k]) res[k*LANE_W +: LANE_W] = nw[k*LANE_W +: LANE_W];
    return res;
  endfunction

  task automatic idle();
    l_ce = 0; r_ce = 0; l_we = 0; r_we = 0; l_be = '0; r_be = '0;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
  endtask

  // one clock of stimulus; inputs already set at the negedge
  task automatic cycle(string tag);
    logic coll, lset, rset, winr, l_inh, r_inh, ebl, ebr;
    string btag;
    #1;
    coll = l_ce && r_ce && (l_addr == r_addr);
    lset = pl_ce && l_ce && (pl_addr == l_addr);
    rset = pr_ce && r_ce && (pr_addr == r_addr);
    if (p_coll)            winr = p_winr;
    else if (rset && !lset) winr = 1;
    else                   winr = 0;
    ebl = master_mode ? !(coll && winr)  : 1'b1;
    ebr = master_mode ? !(coll && !winr) : 1'b1;
    if (!master_mode)            btag = "R6";
    else if (coll && p_coll)     btag = "R4";
    else if (coll && (lset ^ rset)) btag = "R5";
    else                         btag = "R1";
    if (tag != "") btag = tag;
    chk(btag, {31'd0, l_busy_n_o}, {31'd0, ebl}, "left busy_n");
    chk(btag, {31'd0, r_busy_n_o}, {31'd0, ebr}, "right busy_n");
    l_inh = master_mode ? (coll && winr)  : !l_busy_n_i;
    r_inh = master_mode ? (coll && !winr) : !r_busy_n_i;
    if (l_ce && !l_we) exp_l_rd = mdl[l_addr];
    if (r_ce && !r_we) exp_r_rd = mdl[r_addr];
    if (l_ce && l_we && !l_inh) mdl[l_addr] = merge(mdl[l_addr], l_wdata, l_be);
    if (r_ce && r_we && !r_inh) mdl[r_addr] = merge(mdl[r_addr], r_wdata, r_be);
    pl_ce = l_ce; pr_ce = r_ce; pl_addr = l_addr; pr_addr = r_addr;
    p_coll = coll; p_winr = winr;
    @(posedge clk);
    @(negedge clk);
    chk(tag == "" ? "R8" : tag, {16'd0, l_rdata}, {16'd0, exp_l_rd}, "left rdata");
    chk(tag == "" ? "R8" : tag, {16'd0, r_rdata}, {16'd0, exp_r_rd}, "right rdata");
  endtask

  task automatic rd(logic side, logic [AW-1:0] a, string tag);
    idle();
    if (side) begin r_ce = 1; r_addr = a; end
    else      begin l_ce = 1; l_addr = a; end
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; master_mode = 1; l_busy_n_i = 1; r_busy_n_i = 1;
    idle();
    pl_ce = 0; pr_ce = 0; pl_addr = '0; pr_addr = '0; p_coll = 0; p_winr = 0;
    exp_l_rd = '0; exp_r_rd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {31'd0, l_busy_n_o}, 32'd1, "left busy_n after reset");
    chk("R10", {31'd0, r_busy_n_o}, 32'd1, "right busy_n after reset");
    chk("R10", {16'd0, l_rdata}, 32'd0, "left rdata after reset");
    chk("R10", {16'd0, r_rdata}, 32'd0, "right rdata after reset");

    // preload every word from the left port
    for (int a = 0; a < DEPTH; a++) begin
      idle(); l_ce = 1; l_we = 1; l_be = '1; l_addr = AW'(a);
      l_wdata = DW'($urandom);
      cycle("");
    end

    // R9: different addresses, both ports active
    idle(); l_ce = 1; l_we = 1; l_be = '1; l_addr = 5; l_wdata = 16'hA1A1;
    r_ce = 1; r_we = 1; r_be = '1; r_addr = 6; r_wdata = 16'hB2B2;
    cycle("R9");
    idle(); l_ce = 1; l_addr = 6; r_ce = 1; r_addr = 5; cycle("R9");

    // R5: fresh simultaneous arrival -> left wins; both write, left data kept (R3)
    idle(); cycle("");
    l_ce = 1; l_we = 1; l_be = '1; l_addr = 2; l_wdata = 16'h1111;
    r_ce = 1; r_we = 1; r_be = '1; r_addr = 2; r_wdata = 16'h2222;
    cycle("R5");
    // R4: collision held, left keeps winning
    cycle("R4");
    rd(0, 2, "R3");

    // R5: right settled at 3, left arrives -> right wins; R2 reads only
    idle(); r_ce = 1; r_addr = 3; cycle("");
    l_ce = 1; l_addr = 3; cycle("R5");
    // R4 and R2: still right winning with writes now from left (loses, blocked)
    l_we = 1; l_be = '1; l_wdata = 16'hDEAD; cycle("R2");
    rd(1, 3, "R3");

    // R8: losing read returns old data while winning write stores
    idle(); l_ce = 1; l_we = 1; l_be = '1; l_addr = 7; l_wdata = 16'h7777;
    r_ce = 1; r_addr = 7; cycle("R8");
    rd(1, 7, "R8");

    // R7: partial lane writes
    idle(); l_ce = 1; l_we = 1; l_be = 2'b01; l_addr = 9; l_wdata = 16'hCCDD; cycle("R7");
    idle(); r_ce = 1; r_we = 1; r_be = 2'b10; r_addr = 9; r_wdata = 16'hEEFF; cycle("R7");
    rd(0, 9, "R7");

    // random master-role traffic
    for (int i = 0; i < 3000; i++) begin
      l_ce = ($urandom_range(0, 9) < 8); r_ce = ($urandom_range(0, 9) < 8);
      l_we = $urandom_range(0, 1); r_we = $urandom_range(0, 1);
      l_be = LANES'($urandom); r_be = LANES'($urandom);
      l_addr = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
      r_addr = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
      l_wdata = DW'($urandom); r_wdata = DW'($urandom);
      l_busy_n_i = $urandom_range(0, 1); r_busy_n_i = $urandom_range(0, 1);
      cycle("");
    end

    // R6: slave role, inhibit inputs, directed then random
    master_mode = 0; l_busy_n_i = 0; r_busy_n_i = 1;
    idle(); l_ce = 1; l_we = 1; l_be = '1; l_addr = 11; l_wdata = 16'h5A5A; cycle("R6");
    l_busy_n_i = 1; rd(0, 11, "R6");
    idle(); l_ce = 1; l_we = 1; l_be = '1; l_addr = 12; l_wdata = 16'h0101;
    r_ce = 1; r_we = 1; r_be = '1; r_addr = 12; r_wdata = 16'h0202; cycle("R6");
    rd(0, 12, "R6");
    for (int i = 0; i < 1500; i++) begin
      l_ce = ($urandom_range(0, 9) < 8); r_ce = ($urandom_range(0, 9) < 8);
      l_we = $urandom_range(0, 1); r_we = $urandom_range(0, 1);
      l_be = LANES'($urandom); r_be = LANES'($urandom);
      l_addr = AW'($urandom_range(0, 3)); r_addr = AW'($urandom_range(0, 3));
      l_wdata = DW'($urandom); r_wdata = DW'($urandom);
      l_busy_n_i = ($urandom_range(0, 2) != 0); r_busy_n_i = ($urandom_range(0, 2) != 0);
      cycle("");
    end

    // final sweep of all words through both ports
    master_mode = 1; l_busy_n_i = 1; r_busy_n_i = 1;
    for (int a = 0; a < DEPTH; a++) begin
      idle(); l_ce = 1; l_addr = AW'(a); r_ce = 1; r_addr = AW'((a + 1) % DEPTH);
      cycle("R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule